// File: doc/BRIEF.md
# In-Order Issue Front End with Global Stall

This block is the front end of a single-issue, in-order core. It fetches one 32-bit instruction word at a time from an instruction memory port, passes it through a decode register and hands it to the execution core through an issue gate. The three stages form a strict forward chain joined by valid/ready handshakes. It never speculates, never cancels and never renames. When anything downstream cannot guarantee progress, the front end simply holds still.

A debug side controls it. It can start free-running fetch, stop it, grant a single step, and overwrite the program counter. Every issued word carries the address it was fetched from, the machine-state word sampled when the fetch was requested, and an endian flag. A word fetched in little-endian mode is byte-reversed by decode, so issue always presents it in big-endian order.

Three inputs from the core hold the chain back. A global busy input freezes decode and the fetch hand-off. A hazard input closes the issue gate. A fault-window mechanism stops anything further from issuing after a load/store, branch or trap instruction leaves, until the core reports that the instruction can no longer raise an exception. A stopped status tells the debug side that the controller is halted and every function unit is idle.

Back-pressure rules:
- A transfer happens on a rising clock edge where valid and ready are both high.
- `iss_valid` and its payload stay stable while `iss_ready` is low, unless busy or hazard withdraws them. The same instruction then reappears later.
- `imem_req_valid` may fall without a transfer when the controller stops.
- `imem_rsp_valid` is accepted only while a request is outstanding, and at most one request is ever outstanding.

Top module: `inorder_issue_ctrl`

## Requirements
- R1: After reset the controller is halted. With `fu_busy_i` all zero, `dbg_stopped` is 1, `imem_req_valid` is 0 and `iss_valid` is 0.
- R2: A `dbg_start` pulse starts continuous fetching. A `dbg_stop` pulse ends new requests, and instructions already in flight still drain to issue. When both arrive in the same cycle, stop wins.
- R3: A `dbg_step` pulse while halted fetches and issues exactly one instruction, after which `dbg_stopped` returns to 1.
- R4: Fetch addresses start at the last value written through `dbg_pc_we`/`dbg_pc_wdata` and rise by 4 on each accepted request. A debug write takes priority over the increment.
- R5: Each issued instruction carries the pc it was fetched from and the `msr_i` value sampled in the cycle its request was accepted.
- R6: When bit `MSR_LE_BIT` (default bit 0) of the sampled msr is 1, the returned word is byte-reversed and `iss_bigend` is 0. Otherwise the word passes unchanged and `iss_bigend` is 1.
- R7: While `core_busy_i` is high, `iss_valid` is low and decode neither accepts nor releases an instruction.
- R8: While `hazard_i` is high, `iss_valid` is low and the issue stage takes nothing from decode.
- R9: Every fetched instruction is issued exactly once, in fetch order, under any mix of memory latency, busy, hazard and `iss_ready` back-pressure.
- R10: `iss_may_fault` is 1 when instruction bits [31:26] (big-endian order) are 2, 3, 16, 17, 18, 19 or any value of 32 or more. After such an instruction issues, nothing further issues until `exc_clear_i` has been sampled high on a clock edge. Issue may resume from the following cycle.
- R11: `dbg_stopped` is 1 exactly when the controller is not running, no step is pending, fetch is idle, decode is empty, no fault window is open, and the OR of `fu_busy_i` is 0. It follows `fu_busy_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_start | input | 1 | Debug: begin continuous fetch |
| dbg_stop | input | 1 | Debug: halt new fetches |
| dbg_step | input | 1 | Debug: fetch and issue one instruction while halted |
| dbg_pc_we | input | 1 | Debug: write the program counter |
| dbg_pc_wdata | input | 64 | Debug: new program counter value |
| dbg_stopped | output | 1 | Halted and all function units idle |
| msr_i | input | 64 | Machine-state word sampled at each fetch request |
| imem_req_valid | output | 1 | Instruction fetch request valid |
| imem_req_ready | input | 1 | Memory accepts the request |
| imem_req_addr | output | 64 | Fetch byte address |
| imem_rsp_valid | input | 1 | Returned instruction word is valid |
| imem_rsp_data | input | 32 | Returned instruction word, memory byte order |
| core_busy_i | input | 1 | Global stall |
| hazard_i | input | 1 | Register hazard on the instruction at issue |
| fu_busy_i | input | NUM_FU | Per function unit busy flags |
| exc_clear_i | input | 1 | Fault window of the last risky instruction has closed |
| iss_valid | output | 1 | Issue payload valid |
| iss_ready | input | 1 | Core accepts the instruction |
| iss_insn | output | 32 | Instruction word, big-endian order |
| iss_pc | output | 64 | Address of the instruction |
| iss_msr | output | 64 | Machine-state word sampled at fetch |
| iss_bigend | output | 1 | 1 when fetched in big-endian mode |
| iss_may_fault | output | 1 | Instruction is load/store, branch or trap |

## Verification
From an accepted request, the response can come one cycle later at the earliest. The decode register fills on the hand-off edge after the response. The issue gate is combinational from decode, so an instruction can leave on the next edge. `dbg_stopped` and the busy and hazard gating act in the same cycle as their inputs, while a fault-window clear takes effect one edge after `exc_clear_i` is sampled.

The bench drives inputs just after a falling edge and samples one time unit later. It therefore observes exactly the values that the next rising edge acts on. The memory model pushes each expected instruction into a queue at its request edge, and the issue monitor pops from that queue at each transfer edge.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int INSN_W     = 32;
  localparam int PC_W       = 64;
  localparam int MSR_W      = 64;
  localparam int INSN_BYTES = INSN_W / 8;
  localparam int OPC_W      = 6;

  typedef struct packed {
    logic [INSN_W-1:0] insn;
    logic [PC_W-1:0]   pc;
    logic [MSR_W-1:0]  msr;
    logic              bigend;
  } fetch_pkt_t;

  typedef struct packed {
    fetch_pkt_t f;
    logic       may_fault;
  } dec_pkt_t;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_WAIT = 2'd1,
    F_HOLD = 2'd2
  } fstate_e;

  function automatic logic [INSN_W-1:0] byte_rev(input logic [INSN_W-1:0] w);
    logic [INSN_W-1:0] r;
    for (int b = 0; b < INSN_BYTES; b++)
      r[b*8 +: 8] = w[(INSN_BYTES-1-b)*8 +: 8];
    return r;
  endfunction

  // load/store (major opcode 32..63), branch (16, 18, 19), trap (2, 3, 17)
  function automatic logic op_may_fault(input logic [OPC_W-1:0] op);
    logic hit;
    hit = op[OPC_W-1];
    case (op)
      6'd2, 6'd3, 6'd16, 6'd17, 6'd18, 6'd19: hit = 1'b1;
      default: ;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/ioc_dbg_ctrl.sv
module ioc_dbg_ctrl #(
  parameter int NUM_FU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              step,
  input  logic              launch,
  input  logic              fe_empty,
  input  logic [NUM_FU-1:0] fu_busy,
  output logic              go,
  output logic              stopped
);
  logic run_q;
  logic credit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      credit_q <= 1'b0;
    end else begin
      if (stop)       run_q <= 1'b0;
      else if (start) run_q <= 1'b1;

      if (stop)                 credit_q <= 1'b0;
      else if (launch)          credit_q <= 1'b0;
      else if (step && !run_q)  credit_q <= 1'b1;
    end
  end

  assign go      = run_q | credit_q;
  assign stopped = !run_q && !credit_q && fe_empty && !(|fu_busy);

  AST_STEP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !run_q) |=> !credit_q); // R3

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !go); // R2
endmodule

// File: rtl/ioc_fetch.sv
module ioc_fetch
  import ioc_pkg::*;
#(
  parameter int MSR_LE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              pc_we,
  input  logic [PC_W-1:0]   pc_wdata,
  input  logic [MSR_W-1:0]  msr_i,
  output logic              imem_req_valid,
  input  logic              imem_req_ready,
  output logic [PC_W-1:0]   imem_req_addr,
  input  logic              imem_rsp_valid,
  input  logic [INSN_W-1:0] imem_rsp_data,
  input  logic              core_busy,
  output logic              out_valid,
  input  logic              out_ready,
  output fetch_pkt_t        out_pkt,
  output logic              launch,
  output logic              idle
);
  fstate_e        st_q;
  logic [PC_W-1:0] pc_q;
  fetch_pkt_t     pkt_q;
  logic           req_fire;
  logic           out_fire;

  assign imem_req_valid = go && (st_q == F_IDLE);
  assign imem_req_addr  = pc_q;
  assign req_fire       = imem_req_valid && imem_req_ready;
  assign out_valid      = (st_q == F_HOLD) && !core_busy;
  assign out_fire       = out_valid && out_ready;
  assign out_pkt        = pkt_q;
  assign launch         = req_fire;
  assign idle           = (st_q == F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= F_IDLE;
      pc_q  <= '0;
      pkt_q <= '0;
    end else begin
      if (pc_we)         pc_q <= pc_wdata;
      else if (req_fire) pc_q <= pc_q + PC_W'(INSN_BYTES);

      case (st_q)
        F_IDLE: if (req_fire) begin
          st_q         <= F_WAIT;
          pkt_q.pc     <= pc_q;
          pkt_q.msr    <= msr_i;
          pkt_q.bigend <= ~msr_i[MSR_LE_BIT];
        end
        F_WAIT: if (imem_rsp_valid) begin
          st_q       <= F_HOLD;
          pkt_q.insn <= imem_rsp_data;
        end
        F_HOLD: if (out_fire) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !pc_we) |=> (pc_q == $past(pc_q) + PC_W'(INSN_BYTES))); // R4

  AST_PC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (pc_q == $past(pc_wdata))); // R4

  AST_HOLD_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == F_HOLD) && !out_fire) |=> ((st_q == F_HOLD) && $stable(pkt_q))); // R9
endmodule

// File: rtl/ioc_decode.sv
module ioc_decode
  import ioc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_busy,
  input  logic       up_valid,
  output logic       up_ready,
  input  fetch_pkt_t up_pkt,
  output logic       dn_valid,
  input  logic       dn_ready,
  output dec_pkt_t   dn_pkt,
  output logic       empty
);
  dec_pkt_t pkt_q;
  dec_pkt_t nxt;
  logic     full_q;
  logic     in_fire;
  logic     out_fire;

  always_comb begin
    nxt.f = up_pkt;
    if (!up_pkt.bigend) nxt.f.insn = byte_rev(up_pkt.insn);
    nxt.may_fault = op_may_fault(nxt.f.insn[INSN_W-1 -: OPC_W]);
  end

  assign dn_valid = full_q && !core_busy;
  assign out_fire = dn_valid && dn_ready;
  assign up_ready = !core_busy && (!full_q || dn_ready);
  assign in_fire  = up_valid && up_ready;
  assign dn_pkt   = pkt_q;
  assign empty    = !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pkt_q  <= '0;
    end else if (in_fire) begin
      full_q <= 1'b1;
      pkt_q  <= nxt;
    end else if (out_fire) begin
      full_q <= 1'b0;
    end
  end

  AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |=> (full_q == $past(full_q) && $stable(pkt_q))); // R7

  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_fire) |=> (full_q && $stable(pkt_q))); // R9
endmodule

// File: rtl/ioc_issue.sv
module ioc_issue
  import ioc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     up_valid,
  output logic     up_ready,
  input  dec_pkt_t up_pkt,
  input  logic     hazard,
  input  logic     exc_clear,
  output logic     out_valid,
  input  logic     out_ready,
  output logic     fence_open
);
  logic fence_q;
  logic out_fire;

  assign out_valid  = up_valid && !hazard && !fence_q;
  assign up_ready   = out_ready && !hazard && !fence_q;
  assign out_fire   = out_valid && out_ready;
  assign fence_open = fence_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          fence_q <= 1'b0;
    else if (out_fire && up_pkt.may_fault) fence_q <= 1'b1;
    else if (exc_clear)                  fence_q <= 1'b0;
  end

  AST_FAULT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && up_pkt.may_fault) |=> !out_valid); // R10

  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_q && !exc_clear) |=> !out_valid); // R10
endmodule

// File: rtl/inorder_issue_ctrl.sv
module inorder_issue_ctrl
  import ioc_pkg::*;
#(
  parameter int NUM_FU     = 4,
  parameter int MSR_LE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_start,
  input  logic              dbg_stop,
  input  logic              dbg_step,
  input  logic              dbg_pc_we,
  input  logic [PC_W-1:0]   dbg_pc_wdata,
  output logic              dbg_stopped,
  input  logic [MSR_W-1:0]  msr_i,
  output logic              imem_req_valid,
  input  logic              imem_req_ready,
  output logic [PC_W-1:0]   imem_req_addr,
  input  logic              imem_rsp_valid,
  input  logic [INSN_W-1:0] imem_rsp_data,
  input  logic              core_busy_i,
  input  logic              hazard_i,
  input  logic [NUM_FU-1:0] fu_busy_i,
  input  logic              exc_clear_i,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [INSN_W-1:0] iss_insn,
  output logic [PC_W-1:0]   iss_pc,
  output logic [MSR_W-1:0]  iss_msr,
  output logic              iss_bigend,
  output logic              iss_may_fault
);
  logic       go, launch, f_idle;
  logic       f_valid, f_ready;
  fetch_pkt_t f_pkt;
  logic       d_valid, d_ready, d_empty;
  dec_pkt_t   d_pkt;
  logic       fence_open;
  logic       fe_empty;

  assign fe_empty = f_idle && d_empty && !fence_open;

  ioc_dbg_ctrl #(.NUM_FU(NUM_FU)) u_dbg (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dbg_start),
    .stop     (dbg_stop),
    .step     (dbg_step),
    .launch   (launch),
    .fe_empty (fe_empty),
    .fu_busy  (fu_busy_i),
    .go       (go),
    .stopped  (dbg_stopped)
  );

  ioc_fetch #(.MSR_LE_BIT(MSR_LE_BIT)) u_fetch (
    .clk            (clk),
    .rst_n          (rst_n),
    .go             (go),
    .pc_we          (dbg_pc_we),
    .pc_wdata       (dbg_pc_wdata),
    .msr_i          (msr_i),
    .imem_req_valid (imem_req_valid),
    .imem_req_ready (imem_req_ready),
    .imem_req_addr  (imem_req_addr),
    .imem_rsp_valid (imem_rsp_valid),
    .imem_rsp_data  (imem_rsp_data),
    .core_busy      (core_busy_i),
    .out_valid      (f_valid),
    .out_ready      (f_ready),
    .out_pkt        (f_pkt),
    .launch         (launch),
    .idle           (f_idle)
  );

  ioc_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_busy (core_busy_i),
    .up_valid  (f_valid),
    .up_ready  (f_ready),
    .up_pkt    (f_pkt),
    .dn_valid  (d_valid),
    .dn_ready  (d_ready),
    .dn_pkt    (d_pkt),
    .empty     (d_empty)
  );

  ioc_issue u_iss (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (d_valid),
    .up_ready   (d_ready),
    .up_pkt     (d_pkt),
    .hazard     (hazard_i),
    .exc_clear  (exc_clear_i),
    .out_valid  (iss_valid),
    .out_ready  (iss_ready),
    .fence_open (fence_open)
  );

  assign iss_insn      = d_pkt.f.insn;
  assign iss_pc        = d_pkt.f.pc;
  assign iss_msr       = d_pkt.f.msr;
  assign iss_bigend    = d_pkt.f.bigend;
  assign iss_may_fault = d_pkt.may_fault;

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_stopped |-> (!imem_req_valid && !iss_valid)); // R11

  AST_BUSY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy_i |-> !iss_valid); // R7

  AST_HAZARD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_i |-> !iss_valid); // R8

  AST_ISSUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !core_busy_i && !hazard_i) |=>
      (core_busy_i || hazard_i || (iss_valid && $stable(iss_pc)))); // R9
endmodule

// File: tb/inorder_issue_ctrl_test.sv
module inorder_issue_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_FU     = 4;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [63:0] pc;
    logic [31:0] insn;
    logic        le;
    logic        fault;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_start = 0, dbg_stop = 0, dbg_step = 0, dbg_pc_we = 0;
  logic [63:0] dbg_pc_wdata = '0;
  logic dbg_stopped;
  logic [63:0] msr_i = '0;
  logic imem_req_valid, imem_req_ready = 0;
  logic [63:0] imem_req_addr;
  logic imem_rsp_valid = 0;
  logic [31:0] imem_rsp_data = '0;
  logic core_busy_i = 0, hazard_i = 0, exc_clear_i = 0;
  logic [NUM_FU-1:0] fu_busy_i = '0;
  logic iss_valid, iss_ready = 1;
  logic [31:0] iss_insn;
  logic [63:0] iss_pc, iss_msr;
  logic iss_bigend, iss_may_fault;

  int n_checks = 0, n_fail = 0, n_issued = 0;
  bit rand_en = 0, clr_en = 1, fence_pend = 0, done = 0;
  int clr_wait = 0;
  logic [63:0] exp_pc = '0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  inorder_issue_ctrl #(.NUM_FU(NUM_FU)) uut (
    .clk(clk), .rst_n(rst_n),
    .dbg_start(dbg_start), .dbg_stop(dbg_stop), .dbg_step(dbg_step),
    .dbg_pc_we(dbg_pc_we), .dbg_pc_wdata(dbg_pc_wdata), .dbg_stopped(dbg_stopped),
    .msr_i(msr_i),
    .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready),
    .imem_req_addr(imem_req_addr), .imem_rsp_valid(imem_rsp_valid),
    .imem_rsp_data(imem_rsp_data),
    .core_busy_i(core_busy_i), .hazard_i(hazard_i), .fu_busy_i(fu_busy_i),
    .exc_clear_i(exc_clear_i),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_insn(iss_insn),
    .iss_pc(iss_pc), .iss_msr(iss_msr), .iss_bigend(iss_bigend),
    .iss_may_fault(iss_may_fault)
  );

  function automatic logic [5:0] op_of(input logic [2:0] i);
    case (i)
      3'd0: return 6'd14; 3'd1: return 6'd16; 3'd2: return 6'd31; 3'd3: return 6'd32;
      3'd4: return 6'd24; 3'd5: return 6'd18; 3'd6: return 6'd58; default: return 6'd2;
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return {op_of(a[4:2]), a[25:0]};
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic fault_of(input logic [31:0] w);
    logic [5:0] op;
    op = w[31:26];
    return (op >= 6'd32) || (op inside {6'd2, 6'd3, 6'd16, 6'd17, 6'd18, 6'd19});
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model / driver: pushes expected items when a request is accepted
  initial begin
    bit pend = 0;
    int lat = 0;
    logic [31:0] word = '0;
    forever begin
      @(negedge clk);
      imem_rsp_valid = 0;
      if (pend) begin
        if (lat == 0) begin imem_rsp_valid = 1; imem_rsp_data = word; pend = 0; end
        else lat--;
      end
      imem_req_ready = rand_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (rst_n && imem_req_valid && imem_req_ready) begin
        exp_t e;
        chk(imem_req_addr == exp_pc, "R4 fetch address", imem_req_addr, exp_pc);
        e.pc = exp_pc; e.insn = mem_word(exp_pc); e.le = msr_i[0];
        e.fault = fault_of(e.insn);
        exp_q.push_back(e);
        word = msr_i[0] ? swap32(mem_word(exp_pc)) : mem_word(exp_pc);
        exp_pc = exp_pc + 64'd4;
        pend = 1; lat = rand_en ? $urandom_range(0, 2) : 0;
      end
    end
  end

  // issue monitor: pops the scoreboard and checks gating rules
  initial begin
    forever begin
      @(negedge clk);
      if (rand_en) begin
        iss_ready   = ($urandom_range(0, 3) != 0);
        core_busy_i = ($urandom_range(0, 6) == 0);
        hazard_i    = ($urandom_range(0, 6) == 0);
      end
      exc_clear_i = 0;
      if (fence_pend && clr_en) begin
        if (clr_wait == 0) exc_clear_i = 1; else clr_wait--;
      end
      #1;
      if (rst_n) begin
        if (core_busy_i) chk(!iss_valid, "R7 busy blocks issue", iss_valid, 0);
        if (hazard_i)    chk(!iss_valid, "R8 hazard blocks issue", iss_valid, 0);
        if (iss_valid && iss_ready) begin
          n_issued++;
          chk(!fence_pend, "R10 issue inside fault window", 1, 0);
          if (exp_q.size() == 0) chk(0, "R9 unexpected issue", iss_pc, 0);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(iss_pc == e.pc, "R5 pc", iss_pc, e.pc);
            chk(iss_msr == {63'd0, e.le}, "R5 msr", iss_msr, {63'd0, e.le});
            chk(iss_insn == e.insn, "R6 insn order", iss_insn, e.insn);
            chk(iss_bigend == !e.le, "R6 endian flag", iss_bigend, !e.le);
            chk(iss_may_fault == e.fault, "R10 may_fault", iss_may_fault, e.fault);
          end
          if (iss_may_fault) begin fence_pend = 1; clr_wait = $urandom_range(0, 3); end
        end else if (exc_clear_i) fence_pend = 0;
      end
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: dbg_start = 1; 1: dbg_stop = 1; 2: dbg_step = 1;
      default: begin dbg_start = 1; dbg_stop = 1; end
    endcase
    @(negedge clk);
    dbg_start = 0; dbg_stop = 0; dbg_step = 0;
  endtask

  task automatic write_pc(input logic [63:0] v);
    @(negedge clk);
    dbg_pc_we = 1; dbg_pc_wdata = v; exp_pc = v;
    @(negedge clk);
    dbg_pc_we = 0;
  endtask

  task automatic wait_stopped(input string req);
    int k;
    k = 0;
    do begin @(negedge clk); #2; k++; end while (!dbg_stopped && k < 3000);
    chk(dbg_stopped, req, dbg_stopped, 1);
  endtask

  task automatic quiet();
    @(negedge clk);
    rand_en = 0; iss_ready = 1; core_busy_i = 0; hazard_i = 0;
  endtask

  task automatic run_until(input int n);
    int k;
    k = 0;
    while (n_issued < n && k < 20000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk(dbg_stopped, "R1 stopped after reset", dbg_stopped, 1);
    chk(!imem_req_valid, "R1 no request after reset", imem_req_valid, 0);
    chk(!iss_valid, "R1 no issue after reset", iss_valid, 0);

    // R2 stop wins over simultaneous start
    pulse(3);
    repeat (5) @(negedge clk); #2;
    chk(dbg_stopped && !imem_req_valid, "R2 stop beats start", imem_req_valid, 0);

    // R4 R9 free run with random back-pressure
    write_pc(64'h1000);
    rand_en = 1;
    pulse(0);
    run_until(40);
    pulse(1);
    wait_stopped("R2 drain after stop");
    quiet();
    chk(exp_q.size() == 0, "R9 all fetched issued", exp_q.size(), 0);
    repeat (10) @(negedge clk); #2;
    chk(!imem_req_valid, "R2 no request when stopped", imem_req_valid, 0);

    // R11 stopped follows function-unit busy
    fu_busy_i = 4'b0010; #1;
    chk(!dbg_stopped, "R11 fu busy clears stopped", dbg_stopped, 0);
    fu_busy_i = 4'b0000; #1;
    chk(dbg_stopped, "R11 fu idle sets stopped", dbg_stopped, 1);

    // R3 single step
    write_pc(64'h2000);
    base = n_issued;
    pulse(2);
    wait_stopped("R3 stopped after step");
    chk(n_issued - base == 1, "R3 one instruction per step", n_issued - base, 1);
    base = n_issued;
    pulse(2);
    wait_stopped("R3 second step");
    chk(n_issued - base == 1, "R3 second step count", n_issued - base, 1);
    chk(exp_q.size() == 0, "R9 step queue empty", exp_q.size(), 0);

    // R6 little-endian run
    msr_i = 64'd1;
    write_pc(64'h4000);
    base = n_issued;
    rand_en = 1;
    pulse(0);
    run_until(base + 20);
    pulse(1);
    wait_stopped("R2 drain little-endian run");
    quiet();
    chk(exp_q.size() == 0, "R9 little-endian queue empty", exp_q.size(), 0);
    msr_i = 64'd0;

    // R10 fault window holds later instructions
    clr_en = 0;
    write_pc(64'h3004);
    base = n_issued;
    pulse(2);
    run_until(base + 1);
    repeat (2) @(negedge clk); #2;
    chk(!dbg_stopped, "R11 open fault window blocks stopped", dbg_stopped, 0);
    pulse(2);
    repeat (20) @(negedge clk);
    chk(n_issued - base == 1, "R10 no issue before clear", n_issued - base, 1);
    clr_en = 1;
    wait_stopped("R10 drain after clear");
    chk(n_issued - base == 2, "R10 issue resumes after clear", n_issued - base, 2);
    chk(exp_q.size() == 0, "R9 final queue empty", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule